// File: doc/BRIEF.md
# Sub-Register Addressable Register File

This block stores eight 32-bit general registers. Each register can be read or written as a whole word, as its lower half-word, or as one of the two bytes of that lower half. Code written for older 8-bit and 16-bit machines therefore keeps running unchanged: a narrow write changes only the field it names, and a narrow read returns that field zero-extended.

The file has one write port and two combinational read ports. Every port carries a register index and a 2-bit view select. Writes commit on the rising clock edge. A read of a register in the same cycle that it is being written therefore returns the value held before that write.

The byte at bits 15:8 can be addressed only on the first four registers. On the other four, a request for that view is rejected: a write is dropped and flagged, and a read returns zero.

Top module: `lane_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero, and reads of any register in any view then return zero.
- R2: View select 2'b00 (word) writes all 32 bits of the indexed register, and a word read returns all 32 bits.
- R3: View select 2'b01 (half) writes bits 15:0 from wr_data[15:0] and leaves bits 31:16 unchanged. A half read returns bits 15:0 in data[15:0].
- R4: View select 2'b10 (low byte) writes bits 7:0 from wr_data[7:0] and leaves bits 31:8 unchanged. A low-byte read returns bits 7:0 in data[7:0]. On index 0 this is the 8-bit accumulator view.
- R5: View select 2'b11 (high byte) on indexes 0 to 3 writes bits 15:8 from wr_data[7:0] and leaves all other bits unchanged. A high-byte read returns bits 15:8 in data[7:0].
- R6: View select 2'b11 on indexes 4 to 7 is illegal. When it is used on the write port, wr_illegal is 1 in that cycle and the register is left unchanged. When it is used on a read port, that port returns zero. wr_illegal is 0 whenever wr_en is 0 or the request is legal.
- R7: Every narrow read returns zeros in all bits above the selected field.
- R8: A read of the register that is being written in the same cycle returns the value held before the clock edge. The new value appears after that edge.
- R9: The two read ports are independent. Each one returns its own index and view in the same cycle, regardless of what the other port reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register index to write |
| wr_sel | input | 2 | Write view: 00 word, 01 half, 10 low byte, 11 high byte |
| wr_data | input | 32 | Write data; narrow views take its low bits |
| wr_illegal | output | 1 | High when a requested write is rejected |
| rd0_idx | input | 3 | Read port 0 index |
| rd0_sel | input | 2 | Read port 0 view |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd1_idx | input | 3 | Read port 1 index |
| rd1_sel | input | 2 | Read port 1 view |
| rd1_data | output | 32 | Read port 1 data, zero-extended |

## Verification
The bench builds the block with its default parameters: 32-bit registers, eight registers, and the high-byte view on the first four. With these values, random traffic covers every index and every view. It also crosses the boundary between index 3 and index 4, where the high-byte view stops being legal. Directed cases add word writes followed by half and byte overwrites, to show that neighbouring bits survive. They also write and read the same register in one cycle, and try a rejected high-byte write on a stack-pointer-class register.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

    typedef enum logic [1:0] {
        VIEW_WORD = 2'b00,
        VIEW_HALF = 2'b01,
        VIEW_BLO  = 2'b10,
        VIEW_BHI  = 2'b11
    } view_e;

endpackage

// File: rtl/lrf_merge.sv
module lrf_merge
    import lrf_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int HALF_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] wr_val,
    input  logic [1:0]      sel,
    input  logic            hi_ok,
    output logic [XLEN-1:0] new_val,
    output logic            legal
);

    localparam int HI_LSB = BYTE_W;
    localparam int HI_MSB = 2 * BYTE_W - 1;

    always_comb begin
        new_val = old_val;
        legal   = 1'b1;
        case (view_e'(sel))
            VIEW_WORD: new_val = wr_val;
            VIEW_HALF: new_val[HALF_W-1:0] = wr_val[HALF_W-1:0];
            VIEW_BLO:  new_val[BYTE_W-1:0] = wr_val[BYTE_W-1:0];
            VIEW_BHI: begin
                if (hi_ok) new_val[HI_MSB:HI_LSB] = wr_val[BYTE_W-1:0];
                else       legal = 1'b0;
            end
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/lrf_view.sv
module lrf_view
    import lrf_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int HALF_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [XLEN-1:0] reg_val,
    input  logic [1:0]      sel,
    input  logic            hi_ok,
    output logic [XLEN-1:0] data
);

    localparam int HI_LSB = BYTE_W;
    localparam int HI_MSB = 2 * BYTE_W - 1;

    always_comb begin
        data = '0;
        case (view_e'(sel))
            VIEW_WORD: data = reg_val;
            VIEW_HALF: data[HALF_W-1:0] = reg_val[HALF_W-1:0];
            VIEW_BLO:  data[BYTE_W-1:0] = reg_val[BYTE_W-1:0];
            VIEW_BHI:  if (hi_ok) data[BYTE_W-1:0] = reg_val[HI_MSB:HI_LSB];
            default:   data = '0;
        endcase
    end

    AST_NARROW_ZEXT: assert final ((view_e'(sel) == VIEW_WORD) || (view_e'(sel) == VIEW_HALF)
                                   || (data[XLEN-1:BYTE_W] == '0)); // R7

endmodule

// File: rtl/lane_regfile.sv
module lane_regfile
    import lrf_pkg::*;
#(
    parameter int XLEN          = 32,
    parameter int NUM_REGS      = 8,
    parameter int NUM_BYTE_REGS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
    input  logic [1:0]                  wr_sel,
    input  logic [XLEN-1:0]             wr_data,
    output logic                        wr_illegal,
    input  logic [$clog2(NUM_REGS)-1:0] rd0_idx,
    input  logic [1:0]                  rd0_sel,
    output logic [XLEN-1:0]             rd0_data,
    input  logic [$clog2(NUM_REGS)-1:0] rd1_idx,
    input  logic [1:0]                  rd1_sel,
    output logic [XLEN-1:0]             rd1_data
);

    localparam int IDX_W  = $clog2(NUM_REGS);
    localparam int NUM_RD = 2;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [NUM_REGS-1:0][XLEN-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [XLEN-1:0] wr_merged;
    logic            wr_legal;
    logic            wr_hi_ok;

    assign wr_hi_ok = (int'(wr_idx) < NUM_BYTE_REGS);

    lrf_merge #(
        .XLEN   (XLEN),
        .HALF_W (HALF_W),
        .BYTE_W (BYTE_W)
    ) u_merge (
        .old_val (st_q.regs[wr_idx]),
        .wr_val  (wr_data),
        .sel     (wr_sel),
        .hi_ok   (wr_hi_ok),
        .new_val (wr_merged),
        .legal   (wr_legal)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_legal) st_d.regs[wr_idx] = wr_merged;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_illegal = wr_en && !wr_legal;

    logic [NUM_RD-1:0][IDX_W-1:0] rd_idx;
    logic [NUM_RD-1:0][1:0]       rd_sel;
    logic [NUM_RD-1:0][XLEN-1:0]  rd_data;

    assign rd_idx[0] = rd0_idx;
    assign rd_idx[1] = rd1_idx;
    assign rd_sel[0] = rd0_sel;
    assign rd_sel[1] = rd1_sel;
    assign rd0_data  = rd_data[0];
    assign rd1_data  = rd_data[1];

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        logic hi_ok;
        assign hi_ok = (int'(rd_idx[p]) < NUM_BYTE_REGS);
        lrf_view #(
            .XLEN   (XLEN),
            .HALF_W (HALF_W),
            .BYTE_W (BYTE_W)
        ) u_view (
            .reg_val (st_q.regs[rd_idx[p]]),
            .sel     (rd_sel[p]),
            .hi_ok   (hi_ok),
            .data    (rd_data[p])
        );
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (st_q.regs == '0)); // R1

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && view_e'(wr_sel) != VIEW_WORD)
        |=> (st_q.regs[$past(wr_idx)][XLEN-1:HALF_W] == $past(st_q.regs[wr_idx][XLEN-1:HALF_W]))); // R3

    AST_HIBYTE_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && view_e'(wr_sel) == VIEW_BHI && !wr_illegal)
        |=> (st_q.regs[$past(wr_idx)][BYTE_W-1:0] == $past(st_q.regs[wr_idx][BYTE_W-1:0]))); // R5

    AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        wr_illegal |=> $stable(st_q.regs)); // R6

    AST_ILLEGAL_ONLY_HI: assert property (@(posedge clk) disable iff (rst)
        wr_illegal |-> (view_e'(wr_sel) == VIEW_BHI && int'(wr_idx) >= NUM_BYTE_REGS)); // R6

    AST_BYTE_KEEPS_HALF_TOP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && view_e'(wr_sel) == VIEW_BLO)
        |=> (st_q.regs[$past(wr_idx)][XLEN-1:BYTE_W] == $past(st_q.regs[wr_idx][XLEN-1:BYTE_W]))); // R4

endmodule

// File: tb/sim_lane_regfile.sv
module sim_lane_regfile;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        wr_illegal;
    logic [2:0]  rd0_idx, rd1_idx;
    logic [1:0]  rd0_sel, rd1_sel;
    logic [31:0] rd0_data, rd1_data;

    always #2 clk = ~clk;

    lane_regfile u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
        .wr_data(wr_data), .wr_illegal(wr_illegal),
        .rd0_idx(rd0_idx), .rd0_sel(rd0_sel), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_sel(rd1_sel), .rd1_data(rd1_data)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    logic [31:0] model [8];

    function automatic logic legal_req(input logic [2:0] idx, input logic [1:0] sel);
        return !(sel == 2'b11 && idx >= 3'd4);
    endfunction

    function automatic logic [31:0] exp_view(input logic [31:0] v, input logic [2:0] idx,
                                             input logic [1:0] sel);
        case (sel)
            2'b00:   return v;
            2'b01:   return {16'h0, v[15:0]};
            2'b10:   return {24'h0, v[7:0]};
            default: return (idx < 3'd4) ? {24'h0, v[15:8]} : 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_merge(input logic [31:0] v, input logic [1:0] sel,
                                              input logic [31:0] d);
        case (sel)
            2'b00:   return d;
            2'b01:   return {v[31:16], d[15:0]};
            2'b10:   return {v[31:8], d[7:0]};
            default: return {v[31:16], d[7:0], v[7:0]};
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at negedge, check reads and flag before the rising edge, then update the model.
    task automatic step(input string tag, input logic we, input logic [2:0] wi,
                        input logic [1:0] ws, input logic [31:0] wd,
                        input logic [2:0] r0i, input logic [1:0] r0s,
                        input logic [2:0] r1i, input logic [1:0] r1s);
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_sel = ws; wr_data = wd;
        rd0_idx = r0i; rd0_sel = r0s; rd1_idx = r1i; rd1_sel = r1s;
        #1;
        check({tag, " rd0"}, rd0_data, exp_view(model[r0i], r0i, r0s));
        check({tag, " rd1"}, rd1_data, exp_view(model[r1i], r1i, r1s));
        check({tag, " illegal"}, {31'h0, wr_illegal}, {31'h0, we && !legal_req(wi, ws)});
        @(posedge clk);
        if (we && legal_req(wi, ws)) model[wi] = exp_merge(model[wi], ws, wd);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; wr_en = 0; wr_idx = 0; wr_sel = 0; wr_data = 0;
        rd0_idx = 0; rd0_sel = 0; rd1_idx = 0; rd1_sel = 0;
        for (int i = 0; i < 8; i++) model[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything reads zero after reset
        for (int i = 0; i < 8; i++) step("R1", 1'b0, 3'd0, 2'b00, 32'h0, 3'(i), 2'b00, 3'(i), 2'b11);

        // R2: full word
        step("R2", 1'b1, 3'd0, 2'b00, 32'h1234_5678, 3'd0, 2'b00, 3'd1, 2'b00);
        step("R2", 1'b0, 3'd0, 2'b00, 32'h0, 3'd0, 2'b00, 3'd0, 2'b01);
        // R3: half keeps upper
        step("R3", 1'b1, 3'd0, 2'b01, 32'hFFFF_BEEF, 3'd0, 2'b00, 3'd0, 2'b01);
        step("R3", 1'b0, 3'd0, 2'b00, 32'h0, 3'd0, 2'b00, 3'd0, 2'b01);
        // R4: low byte of accumulator
        step("R4", 1'b1, 3'd0, 2'b10, 32'hAAAA_AA5A, 3'd0, 2'b10, 3'd0, 2'b00);
        step("R4", 1'b0, 3'd0, 2'b00, 32'h0, 3'd0, 2'b00, 3'd0, 2'b10);
        // R5: high byte of register 3
        step("R5", 1'b1, 3'd3, 2'b00, 32'hDEAD_0011, 3'd3, 2'b00, 3'd3, 2'b11);
        step("R5", 1'b1, 3'd3, 2'b11, 32'h0000_00C3, 3'd3, 2'b11, 3'd3, 2'b00);
        step("R5", 1'b0, 3'd0, 2'b00, 32'h0, 3'd3, 2'b00, 3'd3, 2'b11);
        // R6: high byte on register 4 is rejected
        step("R6", 1'b1, 3'd4, 2'b00, 32'hCAFE_F00D, 3'd4, 2'b00, 3'd4, 2'b11);
        step("R6", 1'b1, 3'd4, 2'b11, 32'h0000_0077, 3'd4, 2'b00, 3'd4, 2'b11);
        step("R6", 1'b0, 3'd4, 2'b11, 32'h0, 3'd4, 2'b00, 3'd7, 2'b11);
        // R7: narrow reads zero-extend
        step("R7", 1'b1, 3'd5, 2'b00, 32'hFFFF_FFFF, 3'd5, 2'b10, 3'd5, 2'b01);
        step("R7", 1'b0, 3'd0, 2'b00, 32'h0, 3'd5, 2'b10, 3'd5, 2'b01);
        // R8: same-cycle read sees old value
        step("R8", 1'b1, 3'd6, 2'b00, 32'h0BAD_CAFE, 3'd6, 2'b00, 3'd6, 2'b10);
        step("R8", 1'b1, 3'd6, 2'b00, 32'h1111_2222, 3'd6, 2'b00, 3'd6, 2'b01);
        step("R8", 1'b0, 3'd6, 2'b00, 32'h0, 3'd6, 2'b00, 3'd6, 2'b00);

        // R9: random mixed traffic on both read ports
        for (int n = 0; n < 3000; n++) begin
            step("R9", 1'($urandom), 3'($urandom), 2'($urandom), $urandom,
                 3'($urandom), 2'($urandom), 3'($urandom), 2'($urandom));
        end

        // R1: reset again clears state
        @(negedge clk); rst = 1'b1; wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = 32'h0;
        for (int i = 0; i < 8; i++) step("R1", 1'b0, 3'd0, 2'b00, 32'h0, 3'(i), 2'b00, 3'(i), 2'b01);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule